// File: doc/BRIEF.md
# AT Command Line Tokenizer

The block sits behind a UART receiver and turns a stream of received characters into command events. Each line must open with the upper-case pair `A`,`T`, followed by an optional command name, an optional `=` and a comma-separated list of parameters. A whitespace byte closes the line. Every completed parameter is reported in its own cycle as a 32-bit value, a type tag and a position index. The end of the line then raises either a one-cycle success pulse, which tells the host side to answer OK, or, at the first offending byte, a one-cycle error pulse.

Numbers carry their radix in their prefix: hexadecimal, binary, octal, decimal, or a lone zero. The token `-1` is a distinct "use default" marker. For the two frame-sending commands the first parameter is instead a raw hex payload. Its bytes are written into a small buffer that the consumer reads by address. After an error the tokenizer drops all input up to the next whitespace byte and then waits for a new line.

Top module: `at_cmd_tokenizer`

## Requirements
- R1: A line starts only with byte `A` then byte `T`, case sensitive; any other non-whitespace first byte, or a byte other than `T` after `A`, pulses `err_o`.
- R2: Space (0x20), tab (0x09), CR (0x0D) and LF (0x0A) end a line; a well-formed line pulses `ok_o` in the cycle after its terminating byte, with `name_o` (first name char in bits 7:0, unused bytes zero) and `name_len_o` showing the name between `AT` and `=`; `ok_o` and `err_o` never pulse together.
- R3: After an error pulse no output pulses until a whitespace byte arrives; the line after it is parsed normally.
- R4: `0x` prefixes hex digits of either case, `0b` prefixes binary, and `0` followed by a digit starts octal; a prefix with no digits is an error.
- R5: A lone `0` gives value 0 and a number starting with 1-9 is decimal; numbers report type 0.
- R6: The token `-1` reports type 1 with value 0xFFFFFFFF; any other token beginning with `-` is an error.
- R7: When the name is `$SF` or `$SL`, the first parameter is a payload of hex digit pairs with no prefix: byte k is written at buffer address k (high nibble first), it reports type 2 with value equal to the byte count, and an empty payload, an odd digit count, a non-hex byte or a 25th digit is an error.
- R8: A digit not valid for the detected radix (8 or 9 in octal, 2 or above in binary, a non-hex byte in hex, a non-digit in decimal) is an error at that byte.
- R9: A digit that would carry the value past 32 bits is an error at that byte.
- R10: `=` ends the name, `,` separates parameters, each completed parameter pulses `par_valid_o` once with an index counting from 0; an empty parameter or a `,` inside the name is an error.
- R11: A name longer than 8 characters is an error at its 9th character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| name_o | output | 64 | Command name characters, first in bits 7:0 |
| name_len_o | output | 4 | Name length, updated with `ok_o` |
| par_valid_o | output | 1 | Parameter completed pulse |
| par_idx_o | output | 4 | Parameter position |
| par_val_o | output | 32 | Parameter value (byte count for payloads) |
| par_type_o | output | 2 | 0 number, 1 default marker, 2 payload |
| ok_o | output | 1 | Line accepted pulse |
| err_o | output | 1 | Syntax error pulse |
| fb_raddr_i | input | 4 | Payload buffer read address |
| fb_rdata_o | output | 8 | Payload buffer read data |

## Verification
The hardest cases to reach are the error edges that depend on accumulated state rather than on one byte: the digit that overflows 32 bits only after ten decimal or nine hex digits, and the 25th payload digit after twelve full bytes. The stimulus drives those exact boundary strings next to their one-shorter legal twins. It follows each error with trailing garbage and a fresh line, so the skip state is both entered and left. The reference model checks every token prefix byte by byte, so an error must pulse on the exact offending byte, not merely somewhere on the line.

// File: rtl/at_tok_pkg.sv
package at_tok_pkg;
  typedef enum logic [2:0] {S_IDLE, S_GOT_A, S_NAME, S_PARM, S_SKIP} line_st_e;
  typedef enum logic [3:0] {
    N_START, N_ZERO, N_DEC, N_HEX0, N_HEX, N_BIN0, N_BIN, N_OCT, N_NEG, N_OPT, N_FRM
  } num_st_e;
  typedef enum logic [1:0] {PT_NUM = 2'd0, PT_OPT = 2'd1, PT_FRM = 2'd2} par_type_e;

  function automatic logic is_ws(logic [7:0] c);
    return (c == 8'h20) || (c == 8'h09) || (c == 8'h0d) || (c == 8'h0a);
  endfunction

  // {valid, nibble}
  function automatic logic [4:0] hex_nib(logic [7:0] c);
    if (c >= "0" && c <= "9") return {1'b1, c[3:0]};
    if (c >= "A" && c <= "F") return {1'b1, c[3:0] + 4'd9};
    if (c >= "a" && c <= "f") return {1'b1, c[3:0] + 4'd9};
    return 5'd0;
  endfunction
endpackage

// File: rtl/at_num_acc.sv
module at_num_acc #(
  parameter int VAL_W = 32
) (
  input  logic [VAL_W-1:0] acc_i,
  input  logic [1:0]       rdx_i,  // 0 bin, 1 oct, 2 dec, 3 hex
  input  logic [3:0]       dig_i,
  output logic [VAL_W-1:0] nxt_o,
  output logic             ovf_o
);
  localparam int EXT_W = VAL_W + 4;
  logic [EXT_W-1:0] a, p, s;

  always_comb begin
    a = {4'b0, acc_i};
    unique case (rdx_i)
      2'd0:    p = a << 1;
      2'd1:    p = a << 3;
      2'd2:    p = (a << 3) + (a << 1);
      default: p = a << 4;
    endcase
    s = p + EXT_W'(dig_i);
  end

  assign nxt_o = s[VAL_W-1:0];
  assign ovf_o = |s[EXT_W-1:VAL_W];
endmodule

// File: rtl/at_frame_buf.sv
module at_frame_buf #(
  parameter int DEPTH = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (32'(raddr_i) < DEPTH) ? mem_q[raddr_i] : 8'h00;

  p_wr_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < DEPTH));
endmodule

// File: rtl/at_cmd_tokenizer.sv
module at_cmd_tokenizer
  import at_tok_pkg::*;
#(
  parameter int NAME_MAX = 8,
  parameter int FB_DEPTH = 12,
  parameter int PIDX_W   = 4,
  localparam int NL_W = $clog2(NAME_MAX + 1),
  localparam int FA_W = $clog2(FB_DEPTH),
  localparam int FC_W = $clog2(FB_DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rx_valid_i,
  input  logic [7:0]            rx_byte_i,
  output logic [NAME_MAX*8-1:0] name_o,
  output logic [NL_W-1:0]       name_len_o,
  output logic                  par_valid_o,
  output logic [PIDX_W-1:0]     par_idx_o,
  output logic [31:0]           par_val_o,
  output logic [1:0]            par_type_o,
  output logic                  ok_o,
  output logic                  err_o,
  input  logic [FA_W-1:0]       fb_raddr_i,
  output logic [7:0]            fb_rdata_o
);
  line_st_e st_q;
  num_st_e  ns_q;
  logic [31:0]     acc_q;
  logic [3:0]      nib_q;
  logic            half_q;
  logic [FC_W-1:0] fcnt_q;
  logic [PIDX_W-1:0] idx_q;
  logic [7:0]      name_q [NAME_MAX];
  logic [NL_W-1:0] ncnt_q;
  logic ok_q, err_q, pv_q;
  logic [31:0] pval_q;
  logic [1:0]  ptype_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [NL_W-1:0]   nlen_q;

  // byte classification
  logic       ws, term, dec_v, bin_v, oct_v, hex_v, frm_name;
  logic [3:0] hval;
  assign ws    = is_ws(rx_byte_i);
  assign term  = ws || (rx_byte_i == ",");
  assign hex_v = hex_nib(rx_byte_i)[4];
  assign hval  = hex_nib(rx_byte_i)[3:0];
  assign dec_v = (rx_byte_i >= "0") && (rx_byte_i <= "9");
  assign oct_v = (rx_byte_i >= "0") && (rx_byte_i <= "7");
  assign bin_v = (rx_byte_i == "0") || (rx_byte_i == "1");
  assign frm_name = (ncnt_q == NL_W'(3)) && (name_q[0] == "$") && (name_q[1] == "S") &&
                    ((name_q[2] == "F") || (name_q[2] == "L"));

  logic [1:0]  rdx;
  logic [31:0] acc_nxt;
  logic        ovf;
  always_comb begin
    unique case (ns_q)
      N_BIN0, N_BIN:  rdx = 2'd0;
      N_ZERO, N_OCT:  rdx = 2'd1;
      N_HEX0, N_HEX:  rdx = 2'd3;
      default:        rdx = 2'd2;
    endcase
  end

  at_num_acc #(.VAL_W(32)) i_acc (
    .acc_i(acc_q), .rdx_i(rdx), .dig_i(hval), .nxt_o(acc_nxt), .ovf_o(ovf)
  );

  // completion of the current parameter
  logic        fin_ok;
  logic [31:0] fin_val;
  logic [1:0]  fin_type;
  always_comb begin
    fin_val  = acc_q;
    fin_type = PT_NUM;
    unique case (ns_q)
      N_ZERO, N_DEC, N_HEX, N_BIN, N_OCT: fin_ok = 1'b1;
      N_OPT: begin fin_ok = 1'b1; fin_val = '1; fin_type = PT_OPT; end
      N_FRM: begin
        fin_ok   = (fcnt_q != '0) && !half_q;
        fin_val  = 32'(fcnt_q);
        fin_type = PT_FRM;
      end
      default: fin_ok = 1'b0;
    endcase
  end

  // one digit step: next number state, or error
  logic    dig_ok, acc_ld;
  num_st_e ns_nxt;
  always_comb begin
    dig_ok = 1'b0;
    acc_ld = 1'b0;
    ns_nxt = ns_q;
    unique case (ns_q)
      N_START: begin
        if (rx_byte_i == "0")      begin dig_ok = 1'b1; ns_nxt = N_ZERO; end
        else if (dec_v)            begin dig_ok = 1'b1; acc_ld = 1'b1; ns_nxt = N_DEC; end
        else if (rx_byte_i == "-") begin dig_ok = 1'b1; ns_nxt = N_NEG; end
      end
      N_ZERO: begin
        if (rx_byte_i == "x")      begin dig_ok = 1'b1; ns_nxt = N_HEX0; end
        else if (rx_byte_i == "b") begin dig_ok = 1'b1; ns_nxt = N_BIN0; end
        else if (oct_v)            begin dig_ok = 1'b1; acc_ld = 1'b1; ns_nxt = N_OCT; end
      end
      N_DEC:         begin dig_ok = dec_v && !ovf; acc_ld = 1'b1; end
      N_OCT:         begin dig_ok = oct_v && !ovf; acc_ld = 1'b1; end
      N_HEX0, N_HEX: begin dig_ok = hex_v && !ovf; acc_ld = 1'b1; ns_nxt = N_HEX; end
      N_BIN0, N_BIN: begin dig_ok = bin_v && !ovf; acc_ld = 1'b1; ns_nxt = N_BIN; end
      N_NEG:         begin dig_ok = (rx_byte_i == "1"); ns_nxt = N_OPT; end
      N_FRM:         dig_ok = hex_v && (half_q || (fcnt_q != FC_W'(FB_DEPTH)));
      default:       dig_ok = 1'b0;
    endcase
  end

  logic fb_we;
  assign fb_we = rx_valid_i && (st_q == S_PARM) && !term && (ns_q == N_FRM) && half_q && hex_v;

  at_frame_buf #(.DEPTH(FB_DEPTH)) i_fbuf (
    .clk_i, .rst_ni, .we_i(fb_we), .waddr_i(fcnt_q[FA_W-1:0]),
    .wdata_i({nib_q, hval}), .raddr_i(fb_raddr_i), .rdata_o(fb_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  ns_q <= N_START;  acc_q <= '0;  nib_q <= '0;
      half_q <= 1'b0;  fcnt_q <= '0;  idx_q <= '0;  ncnt_q <= '0;
      ok_q <= 1'b0;  err_q <= 1'b0;  pv_q <= 1'b0;
      pval_q <= '0;  ptype_q <= '0;  pidx_q <= '0;  nlen_q <= '0;
      for (int i = 0; i < NAME_MAX; i++) name_q[i] <= '0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      pv_q  <= 1'b0;
      if (rx_valid_i) begin
        unique case (st_q)
          S_IDLE: begin
            if (rx_byte_i == "A") st_q <= S_GOT_A;
            else if (!ws) begin err_q <= 1'b1; st_q <= S_SKIP; end
          end
          S_GOT_A: begin
            if (rx_byte_i == "T") begin
              st_q <= S_NAME;  ncnt_q <= '0;  idx_q <= '0;
              for (int i = 0; i < NAME_MAX; i++) name_q[i] <= '0;
            end else begin
              err_q <= 1'b1;
              st_q  <= ws ? S_IDLE : S_SKIP;
            end
          end
          S_NAME: begin
            if (ws) begin
              ok_q <= 1'b1;  nlen_q <= ncnt_q;  st_q <= S_IDLE;
            end else if (rx_byte_i == "=") begin
              st_q <= S_PARM;  acc_q <= '0;  half_q <= 1'b0;  fcnt_q <= '0;
              ns_q <= frm_name ? N_FRM : N_START;
            end else if ((rx_byte_i == ",") || (ncnt_q == NL_W'(NAME_MAX))) begin
              err_q <= 1'b1;  st_q <= S_SKIP;
            end else begin
              for (int i = 0; i < NAME_MAX; i++)
                if (NL_W'(i) == ncnt_q) name_q[i] <= rx_byte_i;
              ncnt_q <= ncnt_q + 1'b1;
            end
          end
          S_PARM: begin
            if (term) begin
              if (fin_ok) begin
                pv_q <= 1'b1;  pval_q <= fin_val;  ptype_q <= fin_type;  pidx_q <= idx_q;
                if (ws) begin
                  ok_q <= 1'b1;  nlen_q <= ncnt_q;  st_q <= S_IDLE;
                end else begin
                  idx_q <= idx_q + 1'b1;  ns_q <= N_START;  acc_q <= '0;
                end
              end else begin
                err_q <= 1'b1;
                st_q  <= ws ? S_IDLE : S_SKIP;
              end
            end else if (!dig_ok) begin
              err_q <= 1'b1;  st_q <= S_SKIP;
            end else begin
              ns_q <= ns_nxt;
              if (acc_ld) acc_q <= acc_nxt;
              if (ns_q == N_FRM) begin
                half_q <= !half_q;
                nib_q  <= hval;
                if (half_q) fcnt_q <= fcnt_q + 1'b1;
              end
            end
          end
          S_SKIP: if (ws) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NAME_MAX; g++) begin : g_name
    assign name_o[g*8 +: 8] = name_q[g];
  end

  assign name_len_o  = nlen_q;
  assign par_valid_o = pv_q;
  assign par_idx_o   = pidx_q;
  assign par_val_o   = pval_q;
  assign par_type_o  = ptype_q;
  assign ok_o        = ok_q;
  assign err_o       = err_q;

  p_ok_err_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_q && err_q));
  p_ok_after_ws_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> $past(rx_valid_i && is_ws(rx_byte_i)));
  p_skip_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SKIP) |=> (!ok_q && !pv_q && !err_q));
  p_opt_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && ptype_q == PT_OPT) |-> (pval_q == '1));
  p_frm_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && ptype_q == PT_FRM) |-> (pval_q >= 1 && pval_q <= FB_DEPTH));
  p_fcnt_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fcnt_q) <= FB_DEPTH);
  p_name_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ncnt_q) <= NAME_MAX);
endmodule

// File: tb/test_at_cmd_tokenizer.sv
module test_at_cmd_tokenizer;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [63:0] name_o;
  logic [3:0] name_len_o, par_idx_o, fb_raddr = 4'd0;
  logic par_valid_o, ok_o, err_o;
  logic [31:0] par_val_o;
  logic [1:0] par_type_o;
  logic [7:0] fb_rdata_o;

  always #5 clk = ~clk;

  at_cmd_tokenizer i_at_cmd_tokenizer (
    .clk_i(clk), .rst_ni, .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .name_o, .name_len_o, .par_valid_o, .par_idx_o, .par_val_o, .par_type_o,
    .ok_o, .err_o, .fb_raddr_i(fb_raddr), .fb_rdata_o
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  string tag = "R0";

  // reference model state
  int m_st = 0, m_idx = 0;
  bit m_frm = 0;
  byte m_name[$];
  byte m_tok[$];
  byte exp_fb[12];
  bit e_ok, e_err, e_pv;
  logic [31:0] e_val;
  int e_type, e_idx, e_nlen;
  logic [63:0] e_name;

  function automatic bit is_ws(byte c);
    return c == 8'h20 || c == 8'h09 || c == 8'h0d || c == 8'h0a;
  endfunction

  function automatic int hv(byte c);
    if (c >= "0" && c <= "9") return int'(c) - 48;
    if (c >= "A" && c <= "F") return int'(c) - 55;
    if (c >= "a" && c <= "f") return int'(c) - 87;
    return -1;
  endfunction

  // validates a token as complete (fin) or as a still-extendable prefix
  function automatic bit tok_ok(input byte s[$], input bit f, input bit fin,
                                output logic [31:0] v, output int ty);
    int base, start, d;
    longint acc;
    v = 0; ty = 0;
    if (f) begin
      if (s.size() > 24) return 0;
      foreach (s[i]) if (hv(s[i]) < 0) return 0;
      if (fin && (s.size() == 0 || s.size() % 2 != 0)) return 0;
      v = 32'(s.size() / 2); ty = 2;
      return 1;
    end
    if (s.size() == 0) return !fin;
    if (s[0] == "-") begin
      if (s.size() >= 2 && s[1] != "1") return 0;
      if (s.size() > 2) return 0;
      if (fin && s.size() != 2) return 0;
      v = '1; ty = 1;
      return 1;
    end
    if (s[0] == "0") begin
      if (s.size() == 1) return 1;
      if (s[1] == "x") begin base = 16; start = 2; end
      else if (s[1] == "b") begin base = 2; start = 2; end
      else begin base = 8; start = 1; end
    end else if (s[0] >= "1" && s[0] <= "9") begin
      base = 10; start = 0;
    end else return 0;
    if (fin && start == 2 && s.size() == 2) return 0;
    acc = 0;
    for (int i = start; i < s.size(); i++) begin
      if (base == 16) d = hv(s[i]);
      else d = (s[i] >= "0" && s[i] <= "9") ? int'(s[i]) - 48 : -1;
      if (d < 0 || d >= base) return 0;
      acc = acc * base + d;
      if (acc > 64'hFFFF_FFFF) return 0;
    end
    v = acc[31:0];
    return 1;
  endfunction

  function automatic logic [63:0] pack_name(input byte s[$]);
    logic [63:0] r = '0;
    foreach (s[i]) r[i*8 +: 8] = s[i];
    return r;
  endfunction

  task automatic m_step(byte c);
    logic [31:0] v;
    int ty;
    byte t[$];
    bit w = is_ws(c);
    e_ok = 0; e_err = 0; e_pv = 0;
    case (m_st)
      0: if (c == "A") m_st = 1; else if (!w) begin e_err = 1; m_st = 4; end
      1: if (c == "T") begin m_st = 2; m_name = {}; m_idx = 0; end
         else begin e_err = 1; m_st = w ? 0 : 4; end
      2: if (w) begin
           e_ok = 1; e_name = pack_name(m_name); e_nlen = m_name.size(); m_st = 0;
         end else if (c == "=") begin
           m_st = 3; m_tok = {};
           m_frm = m_name.size() == 3 && m_name[0] == "$" && m_name[1] == "S" &&
                   (m_name[2] == "F" || m_name[2] == "L");
         end else if (c == "," || m_name.size() == 8) begin
           e_err = 1; m_st = 4;
         end else m_name.push_back(c);
      3: if (w || c == ",") begin
           if (tok_ok(m_tok, m_frm, 1, v, ty)) begin
             e_pv = 1; e_val = v; e_type = ty; e_idx = m_idx;
             if (ty == 2)
               for (int k = 0; k < m_tok.size() / 2; k++)
                 exp_fb[k] = byte'(hv(m_tok[2*k]) * 16 + hv(m_tok[2*k+1]));
             if (w) begin
               e_ok = 1; e_name = pack_name(m_name); e_nlen = m_name.size(); m_st = 0;
             end else begin
               m_idx++; m_tok = {}; m_frm = 0;
             end
           end else begin
             e_err = 1; m_st = w ? 0 : 4;
           end
         end else begin
           t = m_tok; t.push_back(c);
           if (tok_ok(t, m_frm, 0, v, ty)) m_tok = t;
           else begin e_err = 1; m_st = 4; end
         end
      default: if (w) m_st = 0;
    endcase
  endtask

  task automatic compare();
    bit bad;
    nchk++;
    bad = (ok_o !== e_ok) || (err_o !== e_err) || (par_valid_o !== e_pv);
    if (e_pv && !bad)
      bad = (par_val_o !== e_val) || (32'(par_type_o) != e_type) || (32'(par_idx_o) != e_idx);
    if (e_ok && !bad)
      bad = (name_o !== e_name) || (32'(name_len_o) != e_nlen);
    if (bad) begin
      nfail++;
      $display("FAIL %s: ok=%0b/%0b err=%0b/%0b pv=%0b/%0b val=%h/%h type=%0d/%0d idx=%0d/%0d name=%h/%h len=%0d/%0d",
               tag, ok_o, e_ok, err_o, e_err, par_valid_o, e_pv, par_val_o, e_val,
               par_type_o, e_type, par_idx_o, e_idx, name_o, e_name, name_len_o, e_nlen);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rx_valid = 1'b0;
      e_ok = 0; e_err = 0; e_pv = 0;
    end
  endtask

  task automatic send(string t, string s, int gap = 0);
    tag = t;
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      compare();
      rx_valid = 1'b1;
      rx_byte  = s[i];
      m_step(s[i]);
      if (gap > 0) idle(gap);
    end
    idle(2);
  endtask

  task automatic fb_check(string t, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      fb_raddr = 4'(k);
      #1;
      nchk++;
      if (fb_rdata_o !== exp_fb[k]) begin
        nfail++;
        $display("FAIL %s: payload[%0d]=%h expected %h", t, k, fb_rdata_o, exp_fb[k]);
      end
    end
  endtask

  initial begin
    e_ok = 0; e_err = 0; e_pv = 0; e_val = 0; e_type = 0; e_idx = 0; e_nlen = 0; e_name = 0;
    repeat (3) @(negedge clk);
    nchk++;
    if (ok_o !== 1'b0 || err_o !== 1'b0 || par_valid_o !== 1'b0 || name_len_o !== 4'd0) begin
      nfail++;
      $display("FAIL R2 reset: ok=%0b err=%0b pv=%0b len=%0d expected 0 0 0 0",
               ok_o, err_o, par_valid_o, name_len_o);
    end
    rst_ni = 1'b1;
    idle(2);

    send("R2", "AT\n");
    send("R2", "AT$I=10\r");
    send("R1", "at\n");
    send("R1", "AXT AT ");
    send("R4", "AT$TR=0x1F,0b101,017,0xaBc\t");
    send("R5", "AT$X=0,7,123456\n");
    send("R6", "AT$CB=-1,1\n");
    send("R6", "AT$X=-2 AT$X=-1x ");
    send("R7", "AT$SF=0011AABBccdd,1\n");
    fb_check("R7", 6);
    send("R7", "AT$SL=00112233445566778899AABB\n");
    fb_check("R7", 12);
    send("R7", "AT$SF=123\n");
    send("R7", "AT$SF=00112233445566778899AABBC0 AT$SF=\n");
    send("R7", "AT$SF=12G4 AT$SF=,5\n");
    send("R8", "AT$X=08 AT$X=0b12 AT$X=0xG AT$X=1a AT$X=0b ");
    send("R9", "AT$X=4294967295 AT$X=4294967296 ");
    send("R9", "AT$X=0xFFFFFFFF,0x100000000 AT$X=037777777777 AT$X=040000000000 ");
    send("R10", "AT$X=5,,3 AT$X= AT$X=5, ATX,Y ");
    send("R10", "AT$A=1,2,3,4,5 ");
    send("R11", "ATABCDEFGHI ATABCDEFGH ");
    send("R3", "AT$X=9Z9,5 AT\n");
    send("R3", "BT,=1 AT$Q=0x20\n", 1);
    idle(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule